// File: doc/BRIEF.md
# Interval Timer and Interrupt Status Unit

The block sits on a simple 32-bit word-addressed register bus inside a 4 KB window. Software programs a countdown value and a nonzero interrupt mask. The counter then steps down once per prescaled tick, and the block raises a level interrupt when the count reaches zero. Software acknowledges the interrupt by *reading* the timer status register. That read drops the interrupt and restores the count from the stored start value, so the timer runs again with no further write.

Two other read-only registers are present. One returns an identifier taken from an input pin. The other reports a pending local-bus interrupt as an encoded level. Every read returns its data one cycle after the access, from a register. At all other times the read data is zero.

Top module: `ivtimer`

## Requirements
- R1: A write to word offset 2 (timer value) loads the write data into both the live count and the start value. After a write of N (N>0) with the mask nonzero, the interrupt rises on the N-th tick after the write.
- R2: A read of word offset 2 returns the start value, not the live count, even while the count is running.
- R3: The count decrements on a tick only when the start value, the live count and the mask are all nonzero. With a zero mask or a zero start value, no interrupt ever rises.
- R4: `timer_irq` rises on the clock edge at which a tick takes the count from 1 to 0, and at no other edge.
- R5: A read of word offset 3 (timer status) returns zero, clears `timer_irq` on that edge and reloads the live count from the start value.
- R6: Word offset 1 (mask) is a full 32-bit read/write register that returns the last value written.
- R7: A read of word offset 4 (local status) returns 0x24, that is (8+1)<<2, when `lb_pend` is high, and zero when it is low.
- R8: Ticks come exactly every 2^TICK_SHIFT clock cycles, with the first tick 2^TICK_SHIFT cycles after reset. TICK_SHIFT defaults to 14.
- R9: A read of word offset 0 returns `cpu_id`. A write to offset 0 has no effect.
- R10: Reads of word offsets 5 to 1023 return zero, and writes to them change no register.
- R11: A synchronous active-high reset clears the count, the start value, the mask, `timer_irq` and `bus_rdata`.
- R12: Once raised, `timer_irq` stays high until a status read, even if the mask is cleared. The count stays at zero until it is reloaded.
- R13: `bus_rdata` carries the read data on the cycle after a read access and is zero in every cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (10) | Word address within the 4 KB window |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| cpu_id | input | DATA_W (32) | Identifier returned at offset 0 |
| lb_pend | input | 1 | Local-bus interrupt pending |
| timer_irq | output | 1 | Timer interrupt, held until acknowledged |

## Verification
The checker tests several rules on every cycle. It confirms that a status read clears the interrupt and returns zero, and that an unacknowledged interrupt stays high. It confirms that the interrupt rises only on a tick edge and that ticks are evenly spaced. It also confirms that the identifier, local-status, unmapped and idle read data are correct. The bench's scenarios are needed for the behaviour that depends on the hidden count. That covers the N-tick countdown length, the start value read back while the count runs, the suppression of the count by a zero mask or a zero value, the reload after acknowledge, and mid-run reset.

// File: rtl/itv_pkg.sv
package itv_pkg;
  // word offsets inside the register window
  localparam int unsigned OFF_ID    = 0;
  localparam int unsigned OFF_MASK  = 1;
  localparam int unsigned OFF_VALUE = 2;
  localparam int unsigned OFF_TSTAT = 3;
  localparam int unsigned OFF_LSTAT = 4;

  // interrupt level reported by the local status register
  localparam int unsigned LB_LEVEL = 8;

  typedef enum logic [2:0] {
    SEL_ID, SEL_MASK, SEL_VALUE, SEL_TSTAT, SEL_LSTAT, SEL_NONE
  } reg_sel_e;

  function automatic logic [31:0] level_code(input int unsigned lvl);
    return 32'((lvl + 1) << 2);
  endfunction
endpackage

// File: rtl/itv_prescaler.sv
module itv_prescaler #(
  parameter int unsigned TICK_SHIFT = 14
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (TICK_SHIFT == 0) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = TICK_SHIFT;
      logic [PW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
      end
      assign tick = &div_q;
    end
  endgenerate
endmodule

// File: rtl/itv_countdown.sv
module itv_countdown #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             ack,
  input  logic             mask_nz,
  output logic [CNT_W-1:0] start_q,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] live_q;
  logic             step;

  assign step = tick && mask_nz && (start_q != '0) && (live_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q  <= '0;
      start_q <= '0;
      irq     <= 1'b0;
    end else if (load) begin
      live_q  <= load_val;
      start_q <= load_val;
    end else if (ack) begin
      irq    <= 1'b0;
      live_q <= start_q;
    end else if (step) begin
      live_q <= live_q - ONE;
      if (live_q == ONE) irq <= 1'b1;
    end
  end
endmodule

// File: rtl/itv_regfile.sv
module itv_regfile
  import itv_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] cpu_id,
  input  logic              lb_pend,
  input  logic [CNT_W-1:0]  start_val,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              ack,
  output logic              mask_nz,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [DATA_W-1:0] LB_CODE = DATA_W'(level_code(LB_LEVEL));

  reg_sel_e          sel;
  logic              rd_en, wr_en;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFF_ID):    sel = SEL_ID;
      ADDR_W'(OFF_MASK):  sel = SEL_MASK;
      ADDR_W'(OFF_VALUE): sel = SEL_VALUE;
      ADDR_W'(OFF_TSTAT): sel = SEL_TSTAT;
      ADDR_W'(OFF_LSTAT): sel = SEL_LSTAT;
      default:            sel = SEL_NONE;
    endcase
  end

  assign rd_en    = bus_sel && !bus_wr;
  assign wr_en    = bus_sel && bus_wr;
  assign load     = wr_en && (sel == SEL_VALUE);
  assign load_val = CNT_W'(bus_wdata);
  assign ack      = rd_en && (sel == SEL_TSTAT);
  assign mask_nz  = (mask_q != '0);

  always_ff @(posedge clk) begin
    if (rst)                              mask_q <= '0;
    else if (wr_en && (sel == SEL_MASK))  mask_q <= bus_wdata;
  end

  always_comb begin
    case (sel)
      SEL_ID:    rd_mux = cpu_id;
      SEL_MASK:  rd_mux = mask_q;
      SEL_VALUE: rd_mux = DATA_W'(start_val);
      SEL_LSTAT: rd_mux = lb_pend ? LB_CODE : '0;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
    else            bus_rdata <= '0;
  end
endmodule

// File: rtl/ivtimer.sv
module ivtimer #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned TICK_SHIFT = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] cpu_id,
  input  logic              lb_pend,
  output logic              timer_irq
);
  logic             tick_w;
  logic             load_w, ack_w, mask_nz_w;
  logic [CNT_W-1:0] load_val_w, start_w;

  itv_prescaler #(.TICK_SHIFT(TICK_SHIFT)) u_pre (
    .clk(clk), .rst(rst), .tick(tick_w)
  );

  itv_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cpu_id(cpu_id), .lb_pend(lb_pend),
    .start_val(start_w), .load(load_w), .load_val(load_val_w),
    .ack(ack_w), .mask_nz(mask_nz_w), .bus_rdata(bus_rdata)
  );

  itv_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_w), .load(load_w),
    .load_val(load_val_w), .ack(ack_w), .mask_nz(mask_nz_w),
    .start_q(start_w), .irq(timer_irq)
  );
endmodule

// File: rtl/itv_checker.sv
module itv_checker
  import itv_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned TICK_SHIFT = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] cpu_id,
  input logic              lb_pend,
  input logic              timer_irq,
  input logic              tick
);
  localparam int unsigned GW = TICK_SHIFT + 2;
  localparam logic [GW-1:0] GAP_EXP = GW'((1 << TICK_SHIFT) - 1);

  logic rd_any, rd_ack, rd_id, rd_lstat, rd_unmapped;
  assign rd_any      = bus_sel && !bus_wr;
  assign rd_ack      = rd_any && (bus_addr == ADDR_W'(OFF_TSTAT));
  assign rd_id       = rd_any && (bus_addr == ADDR_W'(OFF_ID));
  assign rd_lstat    = rd_any && (bus_addr == ADDR_W'(OFF_LSTAT));
  assign rd_unmapped = rd_any && (bus_addr > ADDR_W'(OFF_LSTAT));

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
    rd_ack |=> (!timer_irq && bus_rdata == '0));

  assert_irq_held_R12: assert property (@(posedge clk) disable iff (rst)
    (timer_irq && !rd_ack) |=> timer_irq);

  assert_rise_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(timer_irq) |-> $past(tick));

  assert_id_read_R9: assert property (@(posedge clk) disable iff (rst)
    rd_id |=> (bus_rdata == $past(cpu_id)));

  assert_lstat_R7: assert property (@(posedge clk) disable iff (rst)
    rd_lstat |=> (bus_rdata == ($past(lb_pend) ? DATA_W'(level_code(LB_LEVEL)) : '0)));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    rd_unmapped |=> (bus_rdata == '0));

  assert_idle_zero_R13: assert property (@(posedge clk) disable iff (rst)
    !rd_any |=> (bus_rdata == '0));

  // tick spacing window counted here rather than through a long $past
  logic [GW-1:0] gap_q;
  logic          armed_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      if (tick) gap_q <= '0;
      else      gap_q <= gap_q + 1'b1;
      if (armed_q && tick)
        assert_tick_spacing_R8: assert (gap_q == GAP_EXP);
    end
  end

  logic rst_seen_q = 1'b0;
  always_ff @(posedge clk) begin
    rst_seen_q <= rst;
    if (rst_seen_q && !rst)
      assert_reset_clear_R11: assert (!timer_irq && bus_rdata == '0);
  end
endmodule

bind ivtimer itv_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TICK_SHIFT(TICK_SHIFT)
) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .cpu_id(cpu_id),
  .lb_pend(lb_pend), .timer_irq(timer_irq), .tick(tick_w)
);

// File: tb/ivtimer_test.sv
module ivtimer_test;
  localparam int TS  = 4;
  localparam int PER = 1 << TS;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] cpu_id = 32'h5EED_0042;
  logic        lb_pend = 1'b0;
  logic        timer_irq;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  ivtimer #(.TICK_SHIFT(TS)) uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_id(cpu_id), .lb_pend(lb_pend), .timer_irq(timer_irq)
  );

  always #2 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // behavioural reference model, stepped on every edge
  int          m_pre = 0;
  logic [31:0] m_cnt = 0, m_rel = 0, m_mask = 0, m_rd = 0;
  bit          m_irq = 0;

  function automatic string rd_tag(bit rd, logic [9:0] a);
    if (!rd) return "R13 idle";
    case (a)
      10'd0: return "R9 id";
      10'd1: return "R6 mask";
      10'd2: return "R2 value";
      10'd3: return "R5 status";
      10'd4: return "R7 lstat";
      default: return "R10 unmapped";
    endcase
  endfunction

  always @(posedge clk) begin
    bit tick, rd;
    string tg;
    cyc++;
    rd = bus_sel && !bus_wr;
    tg = rd_tag(rd, bus_addr);
    if (rst) begin
      m_pre = 0; m_cnt = 0; m_rel = 0; m_mask = 0; m_irq = 0; m_rd = 0;
      tg = "R11 reset";
    end else begin
      tick  = (m_pre == PER - 1);
      m_pre = (m_pre + 1) % PER;
      m_rd  = 0;
      if (rd) begin
        case (bus_addr)
          10'd0: m_rd = cpu_id;
          10'd1: m_rd = m_mask;
          10'd2: m_rd = m_rel;
          10'd4: m_rd = lb_pend ? 32'h24 : 32'h0;
          default: m_rd = 0;
        endcase
      end
      if (bus_sel && bus_wr && bus_addr == 10'd2) begin
        m_cnt = bus_wdata; m_rel = bus_wdata;
      end else if (rd && bus_addr == 10'd3) begin
        m_irq = 0; m_cnt = m_rel;
      end else if (tick && m_rel != 0 && m_cnt != 0 && m_mask != 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) m_irq = 1;
      end
      if (bus_sel && bus_wr && bus_addr == 10'd1) m_mask = bus_wdata;
    end
    #1;
    if (!done) begin
      chk(tg, bus_rdata, m_rd);
      chk("R4 irq model", {31'b0, timer_irq}, {31'b0, m_irq});
    end
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 10'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 10'(a);
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_irq(output int at);
    at = -1;
    for (int i = 0; i < 200; i++) begin
      if (timer_irq) begin at = cyc; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] d;
    int t0, t1;
    idle(3);
    rst = 0;
    @(negedge clk);
    chk("R11 reset irq", {31'b0, timer_irq}, 32'h0);
    chk("R11 reset rdata", bus_rdata, 32'h0);

    rd(0, d); chk("R9 id read", d, 32'h5EED_0042);
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); chk("R9 id write ignored", d, 32'h5EED_0042);
    @(negedge clk); chk("R13 idle after read", bus_rdata, 32'h0);

    wr(1, 32'hA5A5_0F0F);
    rd(1, d); chk("R6 mask readback", d, 32'hA5A5_0F0F);
    wr(1, 32'h0);
    rd(1, d); chk("R6 mask cleared", d, 32'h0);

    rd(4, d); chk("R7 lstat idle", d, 32'h0);
    lb_pend = 1;
    rd(4, d); chk("R7 lstat pending", d, 32'h24);
    lb_pend = 0;

    wr(6, 32'h1234_5678);
    rd(6, d); chk("R10 unmapped read", d, 32'h0);
    rd(1023, d); chk("R10 top offset", d, 32'h0);
    rd(1, d); chk("R10 write left mask", d, 32'h0);

    // zero mask: no count
    wr(2, 32'd2);
    idle(5 * PER);
    chk("R3 masked no irq", {31'b0, timer_irq}, 32'h0);
    rd(2, d); chk("R1 value loaded", d, 32'd2);

    // three-tick countdown length
    wr(2, 32'd3);
    wr(1, 32'h1);
    t0 = cyc;
    idle(PER + 3);
    rd(2, d); chk("R2 start value while running", d, 32'd3);
    wait_irq(t1);
    checks++;
    if (t1 < 0 || t1 - t0 <= 2 * PER || t1 - t0 > 3 * PER + 1) begin
      errors++;
      $display("FAIL R1 countdown: actual=%0d expected in (%0d,%0d]", t1 - t0, 2 * PER, 3 * PER + 1);
    end

    // held through mask clear
    wr(1, 32'h0);
    idle(3 * PER);
    chk("R12 irq held", {31'b0, timer_irq}, 32'h1);
    rd(3, d); chk("R5 status reads zero", d, 32'h0);
    chk("R5 irq cleared", {31'b0, timer_irq}, 32'h0);
    idle(4 * PER);
    chk("R3 reloaded but masked", {31'b0, timer_irq}, 32'h0);

    // zero value never fires
    wr(2, 32'd0);
    wr(1, 32'h1);
    idle(5 * PER);
    chk("R3 zero value no irq", {31'b0, timer_irq}, 32'h0);

    // tick spacing via back-to-back single-tick periods
    wr(2, 32'd1);
    wait_irq(t0);
    rd(3, d);
    wait_irq(t1);
    chk("R8 tick period", 32'(t1 - t0), 32'(PER));
    idle(2 * PER);
    chk("R12 irq stays without ack", {31'b0, timer_irq}, 32'h1);

    // mid-run reset
    wr(2, 32'd5);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R11 irq after reset", {31'b0, timer_irq}, 32'h0);
    rd(1, d); chk("R11 mask after reset", d, 32'h0);
    rd(2, d); chk("R11 value after reset", d, 32'h0);

    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule